// File: doc/BRIEF.md
# Zero-turnaround pipelined synchronous SRAM

This block is a small synchronous SRAM (256 words of 36 bits by default, split into four 9-bit byte lanes) with no dead cycles between reads and writes. Every control input is registered on the rising clock edge. Reads, writes and deselects all travel down one shared pipeline. Read data leaves an output register one edge after the command. Write data arrives late: it is captured on the second edge after the write command. Because of this, a host can issue any mix of commands on consecutive cycles without inserting wait states.

An active-low clock enable freezes the whole block on any edge it covers. An asynchronous output enable gates the data bus. The data bus is split into separate input, output and output-enable signals. A two-bit burst counter lets one loaded address drive up to four accesses. The counter steps either linearly or by XOR interleave, and the access type is kept for the whole burst. When a read targets an address whose write is still waiting for its data, the read returns the pending data merged lane by lane over the array contents.

Top module: `zt_pipe_sram`

## Requirements
- R1: After reset, dq_oe is low. A write whose data edge has not yet occurred when reset is asserted never changes the array.
- R2: A read is taken at a rising edge with cen_n=0, ce_n=0, we_n=1 and adv_ld_n=0. Its word appears on dq_out, with dq_oe high, after the next accepted edge.
- R3: dq_oe follows oe_n without a clock: while oe_n is high, dq_oe is low.
- R4: A write is taken at an edge with cen_n=0, ce_n=0, we_n=0 and adv_ld_n=0. dq_oe is low after the next accepted edge whatever oe_n is. dq_in is captured on the second accepted edge after the command.
- R5: Lane i (dq bits 9*i+8 down to 9*i) is written only if bw_n[i] was 0 with the write command. Other lanes keep their contents.
- R6: A load with ce_n=1 (a deselect) makes dq_oe low after the next accepted edge.
- R7: An edge with cen_n=1 is ignored. No command is taken, no write completes, and dq_out and dq_oe keep their values.
- R8: A read issued on the cycle right after a write to the same address returns that write's data. Lanes with bw_n=0 come from dq_in, and the others come from the array.
- R9: An edge with adv_ld_n=1 continues the last loaded operation at the next burst address. The low two address bits step as base+count (ilv_mode=0 at load) or base XOR count (ilv_mode=1 at load), wrapping in the group of four. The upper bits stay fixed.
- R10: Continuing after a deselect stays deselected until a new load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cen_n | input | 1 | Active-low clock enable; high freezes all state |
| ce_n | input | 1 | Active-low chip select, sampled on load cycles |
| we_n | input | 1 | Low selects write, high selects read on load cycles |
| adv_ld_n | input | 1 | Low loads a new command, high continues the burst |
| ilv_mode | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| bw_n | input | 4 | Active-low byte lane write selects |
| addr | input | 8 | Word address |
| oe_n | input | 1 | Asynchronous active-low output enable |
| dq_in | input | 36 | Write data, sampled two edges after its command |
| dq_out | output | 36 | Read data from the output register |
| dq_oe | output | 1 | High when dq_out should drive the bus |

## Verification
The bench targets a read placed right after a partial write to the same word. A design without the bypass would return stale lanes, and one that merged on the wrong select polarity would corrupt the kept lanes. It stalls with cen_n high while a write command sits on the inputs. A design that ignored the enable in one stage would let output data move, or would write the stalled command's data later. Bursts are run across the four-word wrap in both orders, and a continue is tried after a deselect. A counter that carried into the upper address or lost the chip select would read back the wrong words or drive the bus. A reset is placed between a write command and its data edge to catch a pipeline that does not flush its write stage.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
  // burst group is four words: the counter covers the low two address bits
  localparam int BURST_W = 2;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/zt_burst_seq.sv
module zt_burst_seq
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              adv_ld_n,
  input  logic              ilv_mode,
  input  logic [LANES-1:0]  bw_n,
  input  logic [ADDR_W-1:0] addr,
  output op_e               s1_op,
  output logic [ADDR_W-1:0] s1_addr,
  output logic [LANES-1:0]  s1_bw_n
);
  op_e                bst_op;
  logic               bst_ilv;
  logic [ADDR_W-1:0]  bst_base;
  logic [BURST_W-1:0] bst_cnt;
  logic [BURST_W-1:0] nxt_cnt;
  logic [BURST_W-1:0] nxt_ofs;
  op_e                ld_op;

  always_comb begin
    ld_op   = ce_n ? OP_IDLE : (we_n ? OP_READ : OP_WRITE);
    nxt_cnt = bst_cnt + 1'b1;
    nxt_ofs = bst_ilv ? (bst_base[BURST_W-1:0] ^ nxt_cnt)
                      : (bst_base[BURST_W-1:0] + nxt_cnt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bst_op   <= OP_IDLE;
      bst_ilv  <= 1'b0;
      bst_base <= '0;
      bst_cnt  <= '0;
      s1_op    <= OP_IDLE;
      s1_addr  <= '0;
      s1_bw_n  <= '1;
    end else if (en) begin
      s1_bw_n <= bw_n;
      if (!adv_ld_n) begin
        bst_op   <= ld_op;
        bst_ilv  <= ilv_mode;
        bst_base <= addr;
        bst_cnt  <= '0;
        s1_op    <= ld_op;
        s1_addr  <= addr;
      end else begin
        bst_cnt <= nxt_cnt;
        s1_op   <= bst_op;
        s1_addr <= {bst_base[ADDR_W-1:BURST_W], nxt_ofs};
      end
    end
  end
endmodule

// File: rtl/zt_sram_array.sv
module zt_sram_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    en,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [LANES-1:0]        wbe,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  // byte-enabled simple dual port, read-first: maps onto block RAM
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        for (int l = 0; l < LANES; l++) begin
          if (wbe[l]) mem[waddr][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
        end
      end
      rdata <= mem[raddr];
    end
  end
endmodule

// File: rtl/zt_pipe_sram.sv
module zt_pipe_sram
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cen_n,
  input  logic                    ce_n,
  input  logic                    we_n,
  input  logic                    adv_ld_n,
  input  logic                    ilv_mode,
  input  logic [LANES-1:0]        bw_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe
);
  localparam int DATA_W = LANES * LANE_W;

  logic              en;
  op_e               s1_op;
  logic [ADDR_W-1:0] s1_addr;
  logic [LANES-1:0]  s1_bw_n;

  logic              s2_vld;
  logic [ADDR_W-1:0] s2_addr;
  logic [LANES-1:0]  s2_bw_n;

  logic              out_rd_q;
  logic              byp_hit_q;
  logic [LANES-1:0]  byp_bw_n_q;
  logic [DATA_W-1:0] byp_dat_q;
  logic [DATA_W-1:0] arr_rdata;

  assign en = ~cen_n;

  zt_burst_seq #(.ADDR_W(ADDR_W), .LANES(LANES)) u_seq (
    .clk(clk), .rst(rst), .en(en), .ce_n(ce_n), .we_n(we_n),
    .adv_ld_n(adv_ld_n), .ilv_mode(ilv_mode), .bw_n(bw_n), .addr(addr),
    .s1_op(s1_op), .s1_addr(s1_addr), .s1_bw_n(s1_bw_n)
  );

  // stage 2 holds a write waiting for its late data; output stage holds reads
  always_ff @(posedge clk) begin
    if (rst) begin
      s2_vld     <= 1'b0;
      s2_addr    <= '0;
      s2_bw_n    <= '1;
      out_rd_q   <= 1'b0;
      byp_hit_q  <= 1'b0;
      byp_bw_n_q <= '1;
      byp_dat_q  <= '0;
    end else if (en) begin
      s2_vld     <= (s1_op == OP_WRITE);
      s2_addr    <= s1_addr;
      s2_bw_n    <= s1_bw_n;
      out_rd_q   <= (s1_op == OP_READ);
      byp_hit_q  <= (s1_op == OP_READ) && s2_vld && (s2_addr == s1_addr);
      byp_bw_n_q <= s2_bw_n;
      byp_dat_q  <= dq_in;
    end
  end

  zt_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk(clk), .en(en), .we(s2_vld), .waddr(s2_addr), .wdata(dq_in),
    .wbe(~s2_bw_n), .raddr(s1_addr), .rdata(arr_rdata)
  );

  // lane merge: the write landing on the same edge as the array read wins
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign dq_out[g*LANE_W +: LANE_W] = (byp_hit_q && !byp_bw_n_q[g])
                                        ? byp_dat_q[g*LANE_W +: LANE_W]
                                        : arr_rdata[g*LANE_W +: LANE_W];
  end

  assign dq_oe = out_rd_q & ~oe_n;
endmodule

// File: rtl/zt_pipe_sram_chk.sv
module zt_pipe_sram_chk #(
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst,
  input logic              cen_n,
  input logic              ce_n,
  input logic              we_n,
  input logic              adv_ld_n,
  input logic              oe_n,
  input logic [DATA_W-1:0] dq_out,
  input logic              dq_oe
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    rst_d |-> !dq_oe);

  assert_read_drives_R2: assert property (@(posedge clk) disable iff (rst)
    (!cen_n && !ce_n && we_n && !adv_ld_n) ##1 (!rst && !cen_n) |=> (dq_oe || oe_n));

  assert_oe_gates_R3: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !dq_oe);

  assert_write_release_R4: assert property (@(posedge clk) disable iff (rst)
    (!cen_n && !ce_n && !we_n && !adv_ld_n) ##1 (!rst && !cen_n) |=> !dq_oe);

  assert_deselect_release_R6: assert property (@(posedge clk) disable iff (rst)
    (!cen_n && ce_n && !adv_ld_n) ##1 (!rst && !cen_n) |=> !dq_oe);

  assert_stall_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (cen_n && !rst) |=> $stable(dq_out));
endmodule

bind zt_pipe_sram zt_pipe_sram_chk #(.DATA_W(LANES*LANE_W)) u_chk (
  .clk(clk), .rst(rst), .cen_n(cen_n), .ce_n(ce_n), .we_n(we_n),
  .adv_ld_n(adv_ld_n), .oe_n(oe_n), .dq_out(dq_out), .dq_oe(dq_oe)
);

// File: tb/zt_pipe_sram_bench.sv
module zt_pipe_sram_bench;
  localparam int AW = 8;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cen_n = 1'b0, ce_n = 1'b1, we_n = 1'b1, adv_ld_n = 1'b0, ilv_mode = 1'b0;
  logic [NL-1:0] bw_n = '1;
  logic [AW-1:0] addr = '0;
  logic          oe_n = 1'b0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  zt_pipe_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u_zt_pipe_sram (
    .clk(clk), .rst(rst), .cen_n(cen_n), .ce_n(ce_n), .we_n(we_n),
    .adv_ld_n(adv_ld_n), .ilv_mode(ilv_mode), .bw_n(bw_n), .addr(addr),
    .oe_n(oe_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  typedef struct packed {
    logic [23:0]   tag;
    logic          cen, ce, we, adv, ilv;
    logic [NL-1:0] bw;
    logic [AW-1:0] a;
    logic [DW-1:0] din;
    logic          eoe;
    logic [DW-1:0] edat;
  } vec_t;

  localparam logic [DW-1:0] D10 = 36'h123456789;
  localparam logic [DW-1:0] D11 = 36'h987654321;
  localparam logic [DW-1:0] MRG = 36'h12347FFFF;

  // inputs are applied before the edge; expectation is for outputs after it
  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{"R4 ",0,0,0,0,0,4'b0000,8'h10,36'h0,0,36'h0},             // write 0x10
    '{"R4 ",0,0,0,0,0,4'b0000,8'h11,36'h0,0,36'h0},             // write 0x11, bus released
    '{"R2 ",0,0,1,0,0,4'b1111,8'h10,D10,0,36'h0},               // read 0x10, data for 0x10
    '{"R2 ",0,0,1,0,0,4'b1111,8'h11,D11,1,D10},                 // read 0x11, data for 0x11
    '{"R2 ",0,1,1,0,0,4'b1111,8'h00,36'h0,1,D11},               // deselect
    '{"R6 ",0,0,1,0,0,4'b1111,8'h10,36'h0,0,36'h0},             // read 0x10
    '{"R2 ",0,0,0,0,0,4'b1100,8'h10,36'h0,1,D10},               // partial write 0x10 lanes 0,1
    '{"R4 ",0,0,1,0,0,4'b1111,8'h10,36'h0,0,36'h0},             // read right behind it
    '{"R8 ",0,1,1,0,0,4'b1111,8'h00,36'hFFFFFFFFF,1,MRG},       // late data, bypass merge
    '{"R5 ",0,0,1,0,0,4'b1111,8'h10,36'h0,0,36'h0},             // read 0x10 from array
    '{"R5 ",0,1,1,0,0,4'b1111,8'h00,36'h0,1,MRG},               // deselect
    '{"R7 ",1,0,0,0,0,4'b0000,8'h10,36'h0,1,MRG},               // stalled write ignored
    '{"R7 ",0,1,1,0,0,4'b1111,8'h00,36'h0,0,36'h0},             // deselect
    '{"R7 ",0,0,1,0,0,4'b1111,8'h10,36'h555555555,0,36'h0},     // read 0x10
    '{"R7 ",0,1,1,0,0,4'b1111,8'h00,36'h0,1,MRG},               // array untouched by stall
    '{"R9 ",0,0,0,0,0,4'b0000,8'h21,36'h0,0,36'h0},             // linear write burst at 0x21
    '{"R9 ",0,1,1,1,0,4'b0000,8'h00,36'h0,0,36'h0},             // -> 0x22
    '{"R9 ",0,1,1,1,0,4'b0000,8'h00,36'hA00000001,0,36'h0},     // -> 0x23, data 0x21
    '{"R9 ",0,1,1,1,0,4'b0000,8'h00,36'hA00000002,0,36'h0},     // -> 0x20 wrap, data 0x22
    '{"R9 ",0,1,1,0,0,4'b1111,8'h00,36'hA00000003,0,36'h0},     // deselect, data 0x23
    '{"R9 ",0,0,1,0,1,4'b1111,8'h22,36'hA00000004,0,36'h0},     // interleaved read 0x22, data 0x20
    '{"R9 ",0,1,1,1,0,4'b1111,8'h00,36'h0,1,36'hA00000002},     // -> 0x23
    '{"R9 ",0,1,1,1,0,4'b1111,8'h00,36'h0,1,36'hA00000003},     // -> 0x20
    '{"R9 ",0,1,1,1,0,4'b1111,8'h00,36'h0,1,36'hA00000004},     // -> 0x21
    '{"R9 ",0,1,1,0,0,4'b1111,8'h00,36'h0,1,36'hA00000001},     // deselect
    '{"R10",0,0,0,1,0,4'b0000,8'h00,36'h0,0,36'h0},             // continue after deselect
    '{"R10",0,1,1,0,0,4'b1111,8'h00,36'h0,0,36'h0}              // still idle
  };

  task automatic check(input string req, input logic aoe, input logic eoe,
                       input logic [DW-1:0] ad, input logic [DW-1:0] ed, input logic cmp_d);
    checks++;
    if (aoe !== eoe || (cmp_d && ad !== ed)) begin
      errors++;
      $display("FAIL %s: dq_oe=%0b dq_out=%h, expected dq_oe=%0b dq_out=%h",
               req, aoe, ad, eoe, ed);
    end
  endtask

  task automatic cyc(input logic c, e, w, v, m, input logic [NL-1:0] b,
                     input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cen_n = c; ce_n = e; we_n = w; adv_ld_n = v; ilv_mode = m; bw_n = b; addr = a; dq_in = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", dq_oe, 1'b0, dq_out, '0, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      cyc(VECS[i].cen, VECS[i].ce, VECS[i].we, VECS[i].adv, VECS[i].ilv,
          VECS[i].bw, VECS[i].a, VECS[i].din);
      check(string'(VECS[i].tag), dq_oe, VECS[i].eoe, dq_out, VECS[i].edat, VECS[i].eoe);
    end

    // R3: output enable acts without a clock edge
    cyc(0, 0, 1, 0, 0, 4'b1111, 8'h10, '0);
    cyc(0, 1, 1, 0, 0, 4'b1111, 8'h00, '0);
    check("R3", dq_oe, 1'b1, dq_out, MRG, 1'b1);
    #0.5 oe_n = 1'b1; #0.5;
    check("R3", dq_oe, 1'b0, dq_out, '0, 1'b0);
    #0.5 oe_n = 1'b0; #0.5;
    check("R3", dq_oe, 1'b1, dq_out, MRG, 1'b1);

    // R4: write release ignores oe_n state, shown with oe_n low
    cyc(0, 0, 0, 0, 0, 4'b0000, 8'h40, '0);
    check("R4", dq_oe, 1'b0, dq_out, '0, 1'b0);

    // R1: reset between a write command and its data edge
    cyc(0, 0, 0, 0, 0, 4'b0000, 8'h30, '0);
    @(negedge clk);
    rst = 1'b1; ce_n = 1'b1; dq_in = 36'h777777777;
    repeat (2) @(posedge clk);
    #1;
    check("R1", dq_oe, 1'b0, dq_out, '0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    cyc(0, 0, 1, 0, 0, 4'b1111, 8'h30, 36'h777777777);
    cyc(0, 1, 1, 0, 0, 4'b1111, 8'h00, 36'h777777777);
    check("R1", dq_oe, 1'b1, dq_out, 36'h0, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule